// File: doc/BRIEF.md
# Expansion ROM Boot Decode Override

This block holds the expansion ROM base address register of a PCI-style configuration header, together with the boot-time override logic that register controls. A strap input decides whether the register exists. With the strap low, the register reads as zero and cannot be written. With the strap high, configuration software writes a ROM base address and an enable flag. A separate CPU-side strobe can clear the enable flag later, in case boot software leaves it set.

While the enable flag is set, two things change. First, the top bit of both programmed target retry timeouts is forced high, which lengthens the access window for slow byte-wide boot ROMs. Second, every active PCI transaction aimed at the ROM window or at the boot chip-select window is steered to the boot chip select, whatever the normal address decoder says. The ROM window is matched here against the stored base. The boot window indication comes from the surrounding target.

When the flag is clear, the programmed timeouts pass through unchanged and the chip selects follow the normal decoder.

Top module: `xrom_boot_override`

## Requirements
- R1: After reset the enable flag and the base field are 0. Reading offset 0x30 returns 0, the effective timeouts equal the programmed ones, and `cs_o` is the decoder value while `pci_req_i` is high.
- R2: With the strap high, a configuration write to offset 0x30 takes effect on the next clock. Bits [31:ROM_SIZE_LOG2] and bit 0 read back as written. Bits [ROM_SIZE_LOG2-1:1] always read 0; with the default ROM_SIZE_LOG2 = 16, writing 0xFFFFFFFF reads back 0xFFFF0001.
- R3: With the strap low, offset 0x30 reads 0 and writes to it are dropped. The stored enable flag is also gated off, so timeouts and chip selects behave as if it were 0.
- R4: Writes to any offset other than 0x30 leave the register unchanged, and reads of any other offset return 0.
- R5: While enabled, each effective timeout equals the programmed value with its most significant bit forced to 1 (0x0f becomes 0x8f, 0x07 becomes 0x87, 0x20 becomes 0xa0).
- R6: While not enabled, each effective timeout equals its programmed value, no ROM hit is reported, and `cs_o` equals `dec_cs_i` during an active transaction.
- R7: While enabled, an active transaction with `pci_boot_win_i` high drives `cs_o` to a one-hot with only bit BOOT_CS_IDX set (0b1000 by default), regardless of address and decoder input. When `pci_req_i` is low, `cs_o` is 0.
- R8: While enabled, an active transaction whose address bits [31:ROM_SIZE_LOG2] equal the stored base raises `rom_hit_o` and forces the boot chip select. An address outside the ROM window, with `pci_boot_win_i` low, uses the decoder value.
- R9: A `cpu_clr_i` pulse clears the enable flag on the next clock and keeps the base. If a configuration write to 0x30 occurs in the same cycle, the base takes the written value but the flag ends up 0.
- R10: The override stays in effect on every cycle for as long as the flag stays set, the strap stays high, and no clear or disabling write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_rom_en_i | input | 1 | Strap: expansion ROM register present |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration register offset |
| cfg_wdata_i | input | DW | Configuration write data |
| cfg_rdata_o | output | DW | Configuration read data for `cfg_addr_i` |
| cpu_clr_i | input | 1 | CPU-side clear of the enable flag |
| prog_timeout0_i | input | TO_W | Programmed first retry timeout |
| prog_timeout1_i | input | TO_W | Programmed second retry timeout |
| eff_timeout0_o | output | TO_W | Effective first retry timeout |
| eff_timeout1_o | output | TO_W | Effective second retry timeout |
| pci_req_i | input | 1 | PCI transaction active at the target |
| pci_addr_i | input | DW | PCI transaction address |
| pci_boot_win_i | input | 1 | Transaction targets the boot chip-select window |
| dec_cs_i | input | NUM_CS | Chip selects from the normal address decoder |
| cs_o | output | NUM_CS | Chip selects to the device unit |
| rom_hit_o | output | 1 | Transaction falls in the enabled ROM window |

## Verification
The only stored state is the base and flag register, so a write or clear shows up in the first cycle after the clock edge that captures it. Read data, effective timeouts, `rom_hit_o` and `cs_o` are combinational, so they follow strap, transaction and decoder inputs in the same cycle. The driver changes inputs at the falling edge, one cycle after a write or clear strobe has been sampled. It queues the expected values at that moment. The monitor compares them 2 ns later, still before the next rising edge, so every check sees the state that results from exactly one register update.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
  localparam int unsigned XROM_CFG_OFS = 32'h30;
endpackage

// File: rtl/xrom_bar_reg.sv
module xrom_bar_reg #(
  parameter int unsigned DW       = 32,
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned SZ_LOG2  = 16,
  parameter int unsigned OFS      = 32'h30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strap_i,
  input  logic               cfg_wr_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [DW-1:0]      cfg_wdata_i,
  input  logic               cpu_clr_i,
  output logic [DW-1:0]      rdata_o,
  output logic               rom_en_o,
  output logic [DW-1:SZ_LOG2] base_o
);
  localparam int unsigned PAD_W = SZ_LOG2 - 1;

  logic [DW-1:SZ_LOG2] base_q;
  logic                en_q;
  logic                sel;
  logic                wr_ok;
  logic                unused_wbits;

  assign sel          = (cfg_addr_i == CFG_AW'(OFS));
  assign wr_ok        = cfg_wr_i & sel & strap_i;
  assign unused_wbits = ^cfg_wdata_i[SZ_LOG2-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_ok) base_q <= cfg_wdata_i[DW-1:SZ_LOG2];
      // CPU clear has priority over a same-cycle config write
      if (cpu_clr_i)  en_q <= 1'b0;
      else if (wr_ok) en_q <= cfg_wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel && strap_i) rdata_o = {base_q, {PAD_W{1'b0}}, en_q};
  end

  assign rom_en_o = strap_i & en_q;
  assign base_o   = base_q;
endmodule

// File: rtl/xrom_to_mask.sv
module xrom_to_mask #(
  parameter int unsigned TO_W   = 8,
  parameter int unsigned NUM_TO = 2
) (
  input  logic                           force_i,
  input  logic [NUM_TO-1:0][TO_W-1:0]    prog_i,
  output logic [NUM_TO-1:0][TO_W-1:0]    eff_o
);
  for (genvar g = 0; g < NUM_TO; g++) begin : g_to
    assign eff_o[g] = force_i ? {1'b1, prog_i[g][TO_W-2:0]} : prog_i[g];
  end
endmodule

// File: rtl/xrom_cs_steer.sv
module xrom_cs_steer #(
  parameter int unsigned DW          = 32,
  parameter int unsigned SZ_LOG2     = 16,
  parameter int unsigned NUM_CS      = 4,
  parameter int unsigned BOOT_CS_IDX = 3
) (
  input  logic                rom_en_i,
  input  logic [DW-1:SZ_LOG2] base_i,
  input  logic                pci_req_i,
  input  logic [DW-1:0]       pci_addr_i,
  input  logic                pci_boot_win_i,
  input  logic [NUM_CS-1:0]   dec_cs_i,
  output logic [NUM_CS-1:0]   cs_o,
  output logic                rom_hit_o
);
  localparam logic [NUM_CS-1:0] BOOT_CS = NUM_CS'(1) << BOOT_CS_IDX;

  logic force_boot;
  logic unused_addr_lo;

  assign unused_addr_lo = ^pci_addr_i[SZ_LOG2-1:0];
  assign rom_hit_o  = rom_en_i & pci_req_i & (pci_addr_i[DW-1:SZ_LOG2] == base_i);
  assign force_boot = rom_en_i & pci_req_i & (rom_hit_o | pci_boot_win_i);

  always_comb begin
    if (force_boot)     cs_o = BOOT_CS;
    else if (pci_req_i) cs_o = dec_cs_i;
    else                cs_o = '0;
  end
endmodule

// File: rtl/xrom_boot_override.sv
module xrom_boot_override #(
  parameter int unsigned DW          = 32,
  parameter int unsigned CFG_AW      = 8,
  parameter int unsigned ROM_SIZE_LOG2 = 16,
  parameter int unsigned TO_W        = 8,
  parameter int unsigned NUM_CS      = 4,
  parameter int unsigned BOOT_CS_IDX = 3,
  parameter int unsigned CFG_OFS     = xrom_pkg::XROM_CFG_OFS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_rom_en_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  output logic [DW-1:0]     cfg_rdata_o,
  input  logic              cpu_clr_i,
  input  logic [TO_W-1:0]   prog_timeout0_i,
  input  logic [TO_W-1:0]   prog_timeout1_i,
  output logic [TO_W-1:0]   eff_timeout0_o,
  output logic [TO_W-1:0]   eff_timeout1_o,
  input  logic              pci_req_i,
  input  logic [DW-1:0]     pci_addr_i,
  input  logic              pci_boot_win_i,
  input  logic [NUM_CS-1:0] dec_cs_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic              rom_hit_o
);
  localparam int unsigned NUM_TO = 2;

  logic                      rom_en;
  logic [DW-1:ROM_SIZE_LOG2] rom_base;
  logic [NUM_TO-1:0][TO_W-1:0] to_prog;
  logic [NUM_TO-1:0][TO_W-1:0] to_eff;

  xrom_bar_reg #(
    .DW(DW), .CFG_AW(CFG_AW), .SZ_LOG2(ROM_SIZE_LOG2), .OFS(CFG_OFS)
  ) u_bar (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strap_i    (strap_rom_en_i),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cpu_clr_i  (cpu_clr_i),
    .rdata_o    (cfg_rdata_o),
    .rom_en_o   (rom_en),
    .base_o     (rom_base)
  );

  assign to_prog[0] = prog_timeout0_i;
  assign to_prog[1] = prog_timeout1_i;

  xrom_to_mask #(.TO_W(TO_W), .NUM_TO(NUM_TO)) u_to (
    .force_i(rom_en),
    .prog_i (to_prog),
    .eff_o  (to_eff)
  );

  assign eff_timeout0_o = to_eff[0];
  assign eff_timeout1_o = to_eff[1];

  xrom_cs_steer #(
    .DW(DW), .SZ_LOG2(ROM_SIZE_LOG2), .NUM_CS(NUM_CS), .BOOT_CS_IDX(BOOT_CS_IDX)
  ) u_cs (
    .rom_en_i      (rom_en),
    .base_i        (rom_base),
    .pci_req_i     (pci_req_i),
    .pci_addr_i    (pci_addr_i),
    .pci_boot_win_i(pci_boot_win_i),
    .dec_cs_i      (dec_cs_i),
    .cs_o          (cs_o),
    .rom_hit_o     (rom_hit_o)
  );
endmodule

// File: rtl/xrom_boot_override_chk.sv
module xrom_boot_override_chk #(
  parameter int unsigned DW            = 32,
  parameter int unsigned CFG_AW        = 8,
  parameter int unsigned ROM_SIZE_LOG2 = 16,
  parameter int unsigned TO_W          = 8,
  parameter int unsigned NUM_CS        = 4,
  parameter int unsigned BOOT_CS_IDX   = 3,
  parameter int unsigned CFG_OFS       = 32'h30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strap_rom_en_i,
  input logic              cfg_wr_i,
  input logic [CFG_AW-1:0] cfg_addr_i,
  input logic [DW-1:0]     cfg_rdata_o,
  input logic              cpu_clr_i,
  input logic              rom_en,
  input logic [TO_W-1:0]   prog_timeout0_i,
  input logic [TO_W-1:0]   prog_timeout1_i,
  input logic [TO_W-1:0]   eff_timeout0_o,
  input logic [TO_W-1:0]   eff_timeout1_o,
  input logic              pci_req_i,
  input logic              pci_boot_win_i,
  input logic [NUM_CS-1:0] cs_o
);
  localparam logic [NUM_CS-1:0] BOOT_CS = NUM_CS'(1) << BOOT_CS_IDX;

  AST_RD_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[ROM_SIZE_LOG2-1:1] == '0); // R2
  AST_STRAP_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strap_rom_en_i |-> (cfg_rdata_o == '0) && !rom_en); // R3
  AST_TO_MSB_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en |-> eff_timeout0_o[TO_W-1] && eff_timeout1_o[TO_W-1]
               && (eff_timeout0_o[TO_W-2:0] == prog_timeout0_i[TO_W-2:0])
               && (eff_timeout1_o[TO_W-2:0] == prog_timeout1_i[TO_W-2:0])); // R5
  AST_TO_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_en |-> (eff_timeout0_o == prog_timeout0_i) && (eff_timeout1_o == prog_timeout1_i)); // R6
  AST_BOOT_CS_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en && pci_req_i && pci_boot_win_i |-> cs_o == BOOT_CS); // R7
  AST_IDLE_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pci_req_i |-> cs_o == '0); // R7
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clr_i |=> !rom_en); // R9
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en && !cpu_clr_i && !(cfg_wr_i && cfg_addr_i == CFG_AW'(CFG_OFS))
    |=> rom_en || !strap_rom_en_i); // R10
endmodule

bind xrom_boot_override xrom_boot_override_chk #(
  .DW(DW), .CFG_AW(CFG_AW), .ROM_SIZE_LOG2(ROM_SIZE_LOG2), .TO_W(TO_W),
  .NUM_CS(NUM_CS), .BOOT_CS_IDX(BOOT_CS_IDX), .CFG_OFS(CFG_OFS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .strap_rom_en_i (strap_rom_en_i),
  .cfg_wr_i       (cfg_wr_i),
  .cfg_addr_i     (cfg_addr_i),
  .cfg_rdata_o    (cfg_rdata_o),
  .cpu_clr_i      (cpu_clr_i),
  .rom_en         (rom_en),
  .prog_timeout0_i(prog_timeout0_i),
  .prog_timeout1_i(prog_timeout1_i),
  .eff_timeout0_o (eff_timeout0_o),
  .eff_timeout1_o (eff_timeout1_o),
  .pci_req_i      (pci_req_i),
  .pci_boot_win_i (pci_boot_win_i),
  .cs_o           (cs_o)
);

// File: tb/xrom_boot_override_bench.sv
module xrom_boot_override_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap_rom_en_i = 1'b1;
  logic        cfg_wr_i = 1'b0;
  logic [7:0]  cfg_addr_i = 8'h30;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        cpu_clr_i = 1'b0;
  logic [7:0]  prog_timeout0_i = 8'h0f;
  logic [7:0]  prog_timeout1_i = 8'h07;
  logic [7:0]  eff_timeout0_o, eff_timeout1_o;
  logic        pci_req_i = 1'b0;
  logic [31:0] pci_addr_i = '0;
  logic        pci_boot_win_i = 1'b0;
  logic [3:0]  dec_cs_i = '0;
  logic [3:0]  cs_o;
  logic        rom_hit_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [31:0] rd;
    logic [7:0]  t0;
    logic [7:0]  t1;
    logic [3:0]  cs;
    logic        hit;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk_i = ~clk_i;

  xrom_boot_override u_xrom_boot_override (.*);

  task automatic push(input string tag, input logic [31:0] rd, input logic [7:0] t0,
                      input logic [7:0] t1, input logic [3:0] cs, input logic hit);
    exp_t e;
    e.rd = rd; e.t0 = t0; e.t1 = t1; e.cs = cs; e.hit = hit;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic cmp(input string tag, input string fld, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  // Monitor: compares queued expectations mid low phase
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      while (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp(t, "rdata", cfg_rdata_o, e.rd);
        cmp(t, "to0", 32'(eff_timeout0_o), 32'(e.t0));
        cmp(t, "to1", 32'(eff_timeout1_o), 32'(e.t1));
        cmp(t, "cs", 32'(cs_o), 32'(e.cs));
        cmp(t, "hit", 32'(rom_hit_o), 32'(e.hit));
      end
    end
  end

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_wr_i = 1'b0; cfg_addr_i = 8'h30;
  endtask

  task automatic cpu_clear();
    @(negedge clk_i);
    cpu_clr_i = 1'b1;
    @(negedge clk_i);
    cpu_clr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    push("R1 reset", 32'h0, 8'h0f, 8'h07, 4'b0000, 1'b0);
    @(negedge clk_i);
    pci_req_i = 1'b1; pci_boot_win_i = 1'b1; dec_cs_i = 4'b0010; pci_addr_i = 32'h1234;
    push("R1 R6 decoder path", 32'h0, 8'h0f, 8'h07, 4'b0010, 1'b0);

    // strap low: writes dropped, reads zero
    @(negedge clk_i); strap_rom_en_i = 1'b0;
    cfg_write(8'h30, 32'hABCD_0001);
    push("R3 strap off read", 32'h0, 8'h0f, 8'h07, 4'b0010, 1'b0);
    @(negedge clk_i); strap_rom_en_i = 1'b1;
    push("R3 write dropped", 32'h0, 8'h0f, 8'h07, 4'b0010, 1'b0);

    // other offset
    cfg_write(8'h34, 32'hABCD_0001);
    push("R4 other offset write", 32'h0, 8'h0f, 8'h07, 4'b0010, 1'b0);
    @(negedge clk_i); cfg_addr_i = 8'h34;
    push("R4 other offset read", 32'h0, 8'h0f, 8'h07, 4'b0010, 1'b0);

    // enable
    cfg_write(8'h30, 32'hABCD_0001);
    push("R2 R5 R7 enable", 32'hABCD_0001, 8'h8f, 8'h87, 4'b1000, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      pci_addr_i = 32'h0100_0000 * i + 32'h55;
      dec_cs_i = 4'(1 << i);
      push("R7 R10 forced any addr", 32'hABCD_0001, 8'h8f, 8'h87, 4'b1000, 1'b0);
    end

    @(negedge clk_i); pci_boot_win_i = 1'b0; pci_addr_i = 32'hABCD_1234; dec_cs_i = 4'b0001;
    push("R8 rom hit", 32'hABCD_0001, 8'h8f, 8'h87, 4'b1000, 1'b1);
    @(negedge clk_i); pci_addr_i = 32'hABCE_0000;
    push("R8 rom miss", 32'hABCD_0001, 8'h8f, 8'h87, 4'b0001, 1'b0);
    @(negedge clk_i); pci_req_i = 1'b0; pci_boot_win_i = 1'b1;
    push("R7 idle", 32'hABCD_0001, 8'h8f, 8'h87, 4'b0000, 1'b0);
    @(negedge clk_i); pci_req_i = 1'b1; prog_timeout0_i = 8'h20; prog_timeout1_i = 8'h7f;
    push("R5 mask other values", 32'hABCD_0001, 8'ha0, 8'hff, 4'b1000, 1'b0);

    cfg_write(8'h30, 32'hFFFF_FFFF);
    push("R2 pad bits zero", 32'hFFFF_0001, 8'ha0, 8'hff, 4'b1000, 1'b0);

    // CPU clear
    cpu_clear();
    push("R9 cpu clear", 32'hFFFF_0000, 8'h20, 8'h7f, 4'b0001, 1'b0);
    @(negedge clk_i); pci_boot_win_i = 1'b0; pci_addr_i = 32'hFFFF_0010;
    push("R6 disabled no hit", 32'hFFFF_0000, 8'h20, 8'h7f, 4'b0001, 1'b0);

    // clear vs write in the same cycle
    cfg_write(8'h30, 32'h1234_0001);
    @(negedge clk_i);
    cfg_wr_i = 1'b1; cfg_wdata_i = 32'h5678_0001; cpu_clr_i = 1'b1;
    @(negedge clk_i);
    cfg_wr_i = 1'b0; cpu_clr_i = 1'b0;
    push("R9 clear wins", 32'h5678_0000, 8'h20, 8'h7f, 4'b0001, 1'b0);

    // re-enable and hold
    cfg_write(8'h30, 32'h1234_0001);
    push("R10 re-enable", 32'h1234_0001, 8'ha0, 8'hff, 4'b0001, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      push("R10 hold", 32'h1234_0001, 8'ha0, 8'hff, 4'b0001, 1'b0);
    end

    // strap gates a set flag
    @(negedge clk_i); strap_rom_en_i = 1'b0; pci_addr_i = 32'h1234_0008;
    push("R3 strap gates flag", 32'h0, 8'h20, 8'h7f, 4'b0001, 1'b0);

    repeat (3) @(negedge clk_i);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule